// File: doc/BRIEF.md
# Accumulator Machine Execute Unit

This block is the execute stage of a 16-bit accumulator machine. Each cycle it can accept one already-decoded instruction: a one-byte opcode, the indices of two general registers (x and y), and a literal word. It reads its operands from its own register file, which holds eight general registers and the accumulator. It evaluates one arithmetic, logical or shift operation and writes the result back one clock edge later. Most operations write the accumulator. Decrement and the two shift families write back into the x register instead.

The register file has two extra ports so the surrounding pipeline, or a bench, can seed and inspect state. One is a load port that can write any entry, the accumulator included. The other is a registered read port. Opcodes outside the arithmetic, logical and shift set are flagged as illegal and change nothing.

Top module: `acc_exec_unit`

## Requirements
- R1: After synchronous reset, res_valid_o, illegal_o, res_data_o and res_dst_o are zero, and every register file entry reads zero.
- R2: Opcode 0x14 writes x+y to the accumulator, and opcode 0x3F writes literal+x to the accumulator. Sums wrap modulo 2^16.
- R3: Opcode 0x1F writes x−y, opcode 0x16 writes x−literal, and opcode 0x1E writes literal−x. All three write the accumulator and use two's-complement wraparound.
- R4: Opcode 0x21 writes the low 16 bits of x·y to the accumulator, and opcode 0x20 writes the low 16 bits of literal·x.
- R5: Opcode 0x36 writes x−1 back into register x. Opcode 0x35 writes x+1 into the accumulator and leaves x unchanged.
- R6: The bitwise operations write the accumulator: 0x2E gives x&y, 0x2F gives x&literal, 0x31 gives x|y, 0x30 gives x|literal, 0x33 gives x^y, 0x32 gives x^literal, and 0x34 gives ~x.
- R7: The shift opcodes write back into register x. 0x27 shifts left by y and 0x26 shifts left by the literal. 0x2B shifts right logically by y and 0x2A shifts right logically by the literal. A shift amount of 16 or more gives zero.
- R8: Any other opcode, issued with op_valid_i high, raises illegal_o for one cycle with res_valid_o low, and no register file entry changes.
- R9: A legal operation sampled at a rising edge updates the register file and raises res_valid_o at that same edge. res_dst_o reports the target: 8 for the accumulator, or the x index 0..7. When no operation is issued, res_valid_o and illegal_o are low in the following cycle.
- R10: The load port writes ld_data_i into entry ld_idx_i (8 is the accumulator) at the clock edge. If an execute write-back targets the same entry at the same edge, the write-back wins. Operands are read before that edge's writes.
- R11: rd_data_o shows entry rd_idx_i as it stood before the sampling edge, one edge after rd_idx_i is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Instruction present this cycle |
| opcode_i | input | 8 | Operation code |
| x_idx_i | input | 3 | First register index (also shift/decrement target) |
| y_idx_i | input | 3 | Second register index |
| imm_i | input | 16 | Literal operand |
| ld_en_i | input | 1 | Load port enable |
| ld_idx_i | input | 4 | Load target (0..7 general, 8 accumulator) |
| ld_data_i | input | 16 | Load value |
| rd_idx_i | input | 4 | Read port index (0..7 general, 8 accumulator) |
| rd_data_o | output | 16 | Registered read data |
| res_valid_o | output | 1 | Result written this cycle |
| res_data_o | output | 16 | Result value |
| res_dst_o | output | 4 | Result target index |
| illegal_o | output | 1 | Unrecognised opcode was issued |

## Verification
The load port and the execute write-back can land on the same register at the same edge. The bench issues a decrement of a register while loading that register in the same cycle. The surviving value must be the decrement of the old contents, and the loaded word must be lost. The same collision is repeated with an addition and an accumulator load. A third case loads a different register alongside the operation, and both writes must then survive.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

  typedef enum logic [3:0] {
    FN_ADD, FN_SUB, FN_MUL, FN_AND, FN_OR, FN_XOR, FN_NOT, FN_SHL, FN_SHR
  } alu_fn_e;

  typedef enum logic [1:0] {
    SEL_X, SEL_Y, SEL_IMM, SEL_ONE
  } opnd_sel_e;

  typedef struct packed {
    logic      legal;
    alu_fn_e   fn;
    opnd_sel_e sel_a;
    opnd_sel_e sel_b;
    logic      to_x;
  } dec_t;

  localparam logic [7:0] OPC_ADD_RR = 8'h14;
  localparam logic [7:0] OPC_ADD_LR = 8'h3F;
  localparam logic [7:0] OPC_SUB_RR = 8'h1F;
  localparam logic [7:0] OPC_SUB_RL = 8'h16;
  localparam logic [7:0] OPC_SUB_LR = 8'h1E;
  localparam logic [7:0] OPC_MUL_RR = 8'h21;
  localparam logic [7:0] OPC_MUL_LR = 8'h20;
  localparam logic [7:0] OPC_DEC    = 8'h36;
  localparam logic [7:0] OPC_INC    = 8'h35;
  localparam logic [7:0] OPC_AND_RR = 8'h2E;
  localparam logic [7:0] OPC_AND_RL = 8'h2F;
  localparam logic [7:0] OPC_OR_RR  = 8'h31;
  localparam logic [7:0] OPC_OR_RL  = 8'h30;
  localparam logic [7:0] OPC_XOR_RR = 8'h33;
  localparam logic [7:0] OPC_XOR_RL = 8'h32;
  localparam logic [7:0] OPC_NOT    = 8'h34;
  localparam logic [7:0] OPC_SHL_RR = 8'h27;
  localparam logic [7:0] OPC_SHL_RL = 8'h26;
  localparam logic [7:0] OPC_SHR_RR = 8'h2B;
  localparam logic [7:0] OPC_SHR_RL = 8'h2A;

endpackage

// File: rtl/acc_exec_decode.sv
module acc_exec_decode
  import acc_exec_pkg::*;
(
  input  logic [7:0] opcode_i,
  output dec_t       dec_o
);

  function automatic dec_t mk(alu_fn_e fn, opnd_sel_e a, opnd_sel_e b, logic to_x);
    dec_t d;
    d.legal = 1'b1;
    d.fn    = fn;
    d.sel_a = a;
    d.sel_b = b;
    d.to_x  = to_x;
    return d;
  endfunction

  always_comb begin
    dec_o = '{legal: 1'b0, fn: FN_ADD, sel_a: SEL_X, sel_b: SEL_Y, to_x: 1'b0};
    case (opcode_i)
      OPC_ADD_RR: dec_o = mk(FN_ADD, SEL_X,   SEL_Y,   1'b0);
      OPC_ADD_LR: dec_o = mk(FN_ADD, SEL_IMM, SEL_X,   1'b0);
      OPC_SUB_RR: dec_o = mk(FN_SUB, SEL_X,   SEL_Y,   1'b0);
      OPC_SUB_RL: dec_o = mk(FN_SUB, SEL_X,   SEL_IMM, 1'b0);
      OPC_SUB_LR: dec_o = mk(FN_SUB, SEL_IMM, SEL_X,   1'b0);
      OPC_MUL_RR: dec_o = mk(FN_MUL, SEL_X,   SEL_Y,   1'b0);
      OPC_MUL_LR: dec_o = mk(FN_MUL, SEL_IMM, SEL_X,   1'b0);
      OPC_DEC:    dec_o = mk(FN_SUB, SEL_X,   SEL_ONE, 1'b1);
      OPC_INC:    dec_o = mk(FN_ADD, SEL_X,   SEL_ONE, 1'b0);
      OPC_AND_RR: dec_o = mk(FN_AND, SEL_X,   SEL_Y,   1'b0);
      OPC_AND_RL: dec_o = mk(FN_AND, SEL_X,   SEL_IMM, 1'b0);
      OPC_OR_RR:  dec_o = mk(FN_OR,  SEL_X,   SEL_Y,   1'b0);
      OPC_OR_RL:  dec_o = mk(FN_OR,  SEL_X,   SEL_IMM, 1'b0);
      OPC_XOR_RR: dec_o = mk(FN_XOR, SEL_X,   SEL_Y,   1'b0);
      OPC_XOR_RL: dec_o = mk(FN_XOR, SEL_X,   SEL_IMM, 1'b0);
      OPC_NOT:    dec_o = mk(FN_NOT, SEL_X,   SEL_Y,   1'b0);
      OPC_SHL_RR: dec_o = mk(FN_SHL, SEL_X,   SEL_Y,   1'b1);
      OPC_SHL_RL: dec_o = mk(FN_SHL, SEL_X,   SEL_IMM, 1'b1);
      OPC_SHR_RR: dec_o = mk(FN_SHR, SEL_X,   SEL_Y,   1'b1);
      OPC_SHR_RL: dec_o = mk(FN_SHR, SEL_X,   SEL_IMM, 1'b1);
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_exec_alu.sv
module acc_exec_alu
  import acc_exec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_fn_e           fn_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);

  localparam int SH_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] SH_LIM = DATA_W[DATA_W-1:0];

  logic [2*DATA_W-1:0] prod;
  logic                too_far;
  logic [SH_W-1:0]     amt;

  assign prod    = {{DATA_W{1'b0}}, a_i} * {{DATA_W{1'b0}}, b_i};
  assign too_far = (b_i >= SH_LIM);
  assign amt     = b_i[SH_W-1:0];

  always_comb begin
    case (fn_i)
      FN_ADD:  y_o = a_i + b_i;
      FN_SUB:  y_o = a_i - b_i;
      FN_MUL:  y_o = prod[DATA_W-1:0];
      FN_AND:  y_o = a_i & b_i;
      FN_OR:   y_o = a_i | b_i;
      FN_XOR:  y_o = a_i ^ b_i;
      FN_NOT:  y_o = ~a_i;
      FN_SHL:  y_o = too_far ? '0 : (a_i << amt);
      FN_SHR:  y_o = too_far ? '0 : (a_i >> amt);
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/acc_exec_regs.sv
module acc_exec_regs #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  parameter int IDX_W  = 3,
  parameter int DST_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  xa_i,
  input  logic [IDX_W-1:0]  ya_i,
  output logic [DATA_W-1:0] xd_o,
  output logic [DATA_W-1:0] yd_o,
  input  logic              wb_en_i,
  input  logic [DST_W-1:0]  wb_idx_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic              ld_en_i,
  input  logic [DST_W-1:0]  ld_idx_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic [DST_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int ENTRIES = NREG + 1;

  logic [DATA_W-1:0] mem [ENTRIES];

  assign xd_o = mem[xa_i];
  assign yd_o = mem[ya_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
      rd_data_o <= '0;
    end else begin
      if (ld_en_i && (int'(ld_idx_i) < ENTRIES)) mem[ld_idx_i] <= ld_data_i;
      if (wb_en_i && (int'(wb_idx_i) < ENTRIES)) mem[wb_idx_i] <= wb_data_i;
      rd_data_o <= (int'(rd_idx_i) < ENTRIES) ? mem[rd_idx_i] : '0;
    end
  end

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  parameter int IDX_W  = $clog2(NREG),
  parameter int DST_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid_i,
  input  logic [7:0]        opcode_i,
  input  logic [IDX_W-1:0]  x_idx_i,
  input  logic [IDX_W-1:0]  y_idx_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic              ld_en_i,
  input  logic [DST_W-1:0]  ld_idx_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic [DST_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic [DST_W-1:0]  res_dst_o,
  output logic              illegal_o
);

  localparam logic [DST_W-1:0] ACC_IDX = NREG[DST_W-1:0];

  dec_t              dec;
  logic [DATA_W-1:0] xv, yv, opa, opb, alu_y;
  logic [DST_W-1:0]  dst;
  logic              wb_en;

  acc_exec_decode u_dec (
    .opcode_i (opcode_i),
    .dec_o    (dec)
  );

  acc_exec_regs #(
    .DATA_W (DATA_W), .NREG (NREG), .IDX_W (IDX_W), .DST_W (DST_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .xa_i      (x_idx_i),
    .ya_i      (y_idx_i),
    .xd_o      (xv),
    .yd_o      (yv),
    .wb_en_i   (wb_en),
    .wb_idx_i  (dst),
    .wb_data_i (alu_y),
    .ld_en_i   (ld_en_i),
    .ld_idx_i  (ld_idx_i),
    .ld_data_i (ld_data_i),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o)
  );

  function automatic logic [DATA_W-1:0] pick(opnd_sel_e s, logic [DATA_W-1:0] x,
                                             logic [DATA_W-1:0] y, logic [DATA_W-1:0] k);
    case (s)
      SEL_X:   return x;
      SEL_Y:   return y;
      SEL_IMM: return k;
      default: return {{(DATA_W-1){1'b0}}, 1'b1};
    endcase
  endfunction

  always_comb begin
    opa = pick(dec.sel_a, xv, yv, imm_i);
    opb = pick(dec.sel_b, xv, yv, imm_i);
  end

  acc_exec_alu #(.DATA_W (DATA_W)) u_alu (
    .fn_i (dec.fn),
    .a_i  (opa),
    .b_i  (opb),
    .y_o  (alu_y)
  );

  assign dst   = dec.to_x ? {1'b0, x_idx_i} : ACC_IDX;
  assign wb_en = op_valid_i && dec.legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o <= 1'b0;
      illegal_o   <= 1'b0;
      res_data_o  <= '0;
      res_dst_o   <= '0;
    end else begin
      res_valid_o <= wb_en;
      illegal_o   <= op_valid_i && !dec.legal;
      if (wb_en) begin
        res_data_o <= alu_y;
        res_dst_o  <= dst;
      end
    end
  end

endmodule

// File: rtl/acc_exec_chk.sv
module acc_exec_chk #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  parameter int IDX_W  = 3,
  parameter int DST_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid_i,
  input logic [7:0]        opcode_i,
  input logic [IDX_W-1:0]  x_idx_i,
  input logic [DATA_W-1:0] imm_i,
  input logic              res_valid_o,
  input logic [DATA_W-1:0] res_data_o,
  input logic [DST_W-1:0]  res_dst_o,
  input logic              illegal_o
);

  localparam logic [DST_W-1:0] ACC_IDX = NREG[DST_W-1:0];
  localparam logic [DATA_W-1:0] LIM = DATA_W[DATA_W-1:0];

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({res_valid_o, illegal_o})); // R8

  AST_ISSUE_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    op_valid_i |=> (res_valid_o || illegal_o)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !op_valid_i |=> (!res_valid_o && !illegal_o)); // R9

  AST_ADD_TO_ACC: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && (opcode_i == 8'h14 || opcode_i == 8'h3F)) |=> (res_dst_o == ACC_IDX)); // R2

  AST_DEC_TO_SRC: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && opcode_i == 8'h36) |=> (res_dst_o == {1'b0, $past(x_idx_i)})); // R5

  AST_WIDE_SHIFT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && (opcode_i == 8'h26 || opcode_i == 8'h2A) && imm_i >= LIM)
      |=> (res_data_o == '0 && res_dst_o == {1'b0, $past(x_idx_i)})); // R7

endmodule

bind acc_exec_unit acc_exec_chk #(
  .DATA_W (DATA_W), .NREG (NREG), .IDX_W (IDX_W), .DST_W (DST_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_valid_i  (op_valid_i),
  .opcode_i    (opcode_i),
  .x_idx_i     (x_idx_i),
  .imm_i       (imm_i),
  .res_valid_o (res_valid_o),
  .res_data_o  (res_data_o),
  .res_dst_o   (res_dst_o),
  .illegal_o   (illegal_o)
);

// File: tb/sim_acc_exec_unit.sv
module sim_acc_exec_unit;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] ACC = 4'd8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [2:0]  x_idx_i = '0;
  logic [2:0]  y_idx_i = '0;
  logic [15:0] imm_i = '0;
  logic        ld_en_i = 1'b0;
  logic [3:0]  ld_idx_i = '0;
  logic [15:0] ld_data_i = '0;
  logic [3:0]  rd_idx_i = '0;
  logic [15:0] rd_data_o, res_data_o;
  logic        res_valid_o, illegal_o;
  logic [3:0]  res_dst_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_exec_unit u0 (
    .clk (clk), .rst (rst),
    .op_valid_i (op_valid_i), .opcode_i (opcode_i),
    .x_idx_i (x_idx_i), .y_idx_i (y_idx_i), .imm_i (imm_i),
    .ld_en_i (ld_en_i), .ld_idx_i (ld_idx_i), .ld_data_i (ld_data_i),
    .rd_idx_i (rd_idx_i), .rd_data_o (rd_data_o),
    .res_valid_o (res_valid_o), .res_data_o (res_data_o),
    .res_dst_o (res_dst_o), .illegal_o (illegal_o)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic load(logic [3:0] idx, logic [15:0] val);
    @(negedge clk);
    ld_en_i = 1'b1; ld_idx_i = idx; ld_data_i = val;
    @(posedge clk); #1;
    ld_en_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] idx, output logic [15:0] val);
    @(negedge clk);
    rd_idx_i = idx;
    @(posedge clk); #1;
    val = rd_data_o;
  endtask

  task automatic issue(logic [7:0] op, logic [2:0] x, logic [2:0] y, logic [15:0] k);
    @(negedge clk);
    op_valid_i = 1'b1; opcode_i = op; x_idx_i = x; y_idx_i = y; imm_i = k;
    @(posedge clk); #1;
    op_valid_i = 1'b0;
  endtask

  task automatic expect_res(string tag, logic [15:0] data, logic [3:0] dst);
    check({tag, " valid"}, res_valid_o, 1'b1);
    check({tag, " data"}, res_data_o, data);
    check({tag, " dst"}, res_dst_o, dst);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 res_valid", res_valid_o, 1'b0);
    check("R1 illegal", illegal_o, 1'b0);
    check("R1 res_data", res_data_o, 16'h0);
    check("R1 res_dst", res_dst_o, 4'h0);
    rd(4'd3, v); check("R1 r3", v, 16'h0);
    rd(ACC, v);  check("R1 acc", v, 16'h0);
  endtask

  task automatic t_add();
    logic [15:0] v;
    load(4'd1, 16'h0005); load(4'd2, 16'h0007);
    issue(8'h14, 3'd1, 3'd2, 16'h0);
    expect_res("R2 add rr", 16'h000C, ACC);
    rd(ACC, v); check("R2 acc after add", v, 16'h000C);
    issue(8'h3F, 3'd1, 3'd0, 16'hFFFF);
    expect_res("R2 add lit wrap", 16'h0004, ACC);
  endtask

  task automatic t_sub();
    issue(8'h1F, 3'd1, 3'd2, 16'h0);
    expect_res("R3 sub rr", 16'hFFFE, ACC);
    issue(8'h16, 3'd1, 3'd0, 16'h0010);
    expect_res("R3 sub reg-lit", 16'hFFF5, ACC);
    issue(8'h1E, 3'd1, 3'd0, 16'h0010);
    expect_res("R3 sub lit-reg", 16'h000B, ACC);
  endtask

  task automatic t_mul();
    load(4'd3, 16'h1234); load(4'd4, 16'h0010);
    issue(8'h21, 3'd3, 3'd4, 16'h0);
    expect_res("R4 mul rr low half", 16'h2340, ACC);
    issue(8'h20, 3'd1, 3'd0, 16'h0003);
    expect_res("R4 mul lit", 16'h000F, ACC);
  endtask

  task automatic t_decinc();
    logic [15:0] v;
    load(4'd5, 16'h0000);
    issue(8'h36, 3'd5, 3'd0, 16'h0);
    expect_res("R5 dec", 16'hFFFF, 4'd5);
    rd(4'd5, v); check("R5 r5 after dec", v, 16'hFFFF);
    issue(8'h35, 3'd5, 3'd0, 16'h0);
    expect_res("R5 inc", 16'h0000, ACC);
    rd(4'd5, v); check("R5 r5 kept after inc", v, 16'hFFFF);
  endtask

  task automatic t_logic();
    load(4'd1, 16'hF0F0); load(4'd2, 16'h3C3C);
    issue(8'h2E, 3'd1, 3'd2, 16'h0);    expect_res("R6 and rr", 16'h3030, ACC);
    issue(8'h31, 3'd1, 3'd2, 16'h0);    expect_res("R6 or rr", 16'hFCFC, ACC);
    issue(8'h33, 3'd1, 3'd2, 16'h0);    expect_res("R6 xor rr", 16'hCCCC, ACC);
    issue(8'h2F, 3'd1, 3'd2, 16'h00FF); expect_res("R6 and lit", 16'h00F0, ACC);
    issue(8'h30, 3'd1, 3'd2, 16'h00FF); expect_res("R6 or lit", 16'hF0FF, ACC);
    issue(8'h32, 3'd1, 3'd2, 16'h00FF); expect_res("R6 xor lit", 16'hF00F, ACC);
    issue(8'h34, 3'd1, 3'd2, 16'h0);    expect_res("R6 not", 16'h0F0F, ACC);
  endtask

  task automatic t_shift();
    logic [15:0] v;
    load(4'd6, 16'h8001); load(4'd7, 16'h0004);
    issue(8'h27, 3'd6, 3'd7, 16'h0);
    expect_res("R7 shl by reg", 16'h0010, 4'd6);
    rd(4'd6, v); check("R7 r6 after shl", v, 16'h0010);
    load(4'd6, 16'h8001);
    issue(8'h2A, 3'd6, 3'd0, 16'd15);
    expect_res("R7 shr lit 15", 16'h0001, 4'd6);
    load(4'd6, 16'h8001);
    issue(8'h26, 3'd6, 3'd0, 16'd16);
    expect_res("R7 shl lit 16", 16'h0000, 4'd6);
    load(4'd6, 16'h8001); load(4'd7, 16'h0100);
    issue(8'h2B, 3'd6, 3'd7, 16'h0);
    expect_res("R7 shr reg 256", 16'h0000, 4'd6);
    rd(4'd6, v); check("R7 r6 cleared", v, 16'h0000);
  endtask

  task automatic t_illegal();
    logic [15:0] v;
    load(ACC, 16'h1111); load(4'd1, 16'h2222);
    issue(8'h00, 3'd1, 3'd1, 16'h0);
    check("R8 illegal flag", illegal_o, 1'b1);
    check("R8 no valid", res_valid_o, 1'b0);
    issue(8'h11, 3'd1, 3'd1, 16'h0);
    check("R8 illegal move opcode", illegal_o, 1'b1);
    rd(ACC, v);  check("R8 acc untouched", v, 16'h1111);
    rd(4'd1, v); check("R8 r1 untouched", v, 16'h2222);
  endtask

  task automatic t_latency();
    issue(8'h35, 3'd1, 3'd0, 16'h0);
    expect_res("R9 inc result next edge", 16'h2223, ACC);
    @(posedge clk); #1;
    check("R9 valid drops when idle", res_valid_o, 1'b0);
    check("R9 illegal low when idle", illegal_o, 1'b0);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    load(4'd2, 16'h0010);
    @(negedge clk);
    op_valid_i = 1'b1; opcode_i = 8'h36; x_idx_i = 3'd2; y_idx_i = 3'd0; imm_i = '0;
    ld_en_i = 1'b1; ld_idx_i = 4'd2; ld_data_i = 16'h0050;
    @(posedge clk); #1;
    op_valid_i = 1'b0; ld_en_i = 1'b0;
    expect_res("R10 dec vs load", 16'h000F, 4'd2);
    rd(4'd2, v); check("R10 write-back wins on r2", v, 16'h000F);
    @(negedge clk);
    op_valid_i = 1'b1; opcode_i = 8'h14; x_idx_i = 3'd2; y_idx_i = 3'd2;
    ld_en_i = 1'b1; ld_idx_i = ACC; ld_data_i = 16'hAAAA;
    @(posedge clk); #1;
    op_valid_i = 1'b0; ld_en_i = 1'b0;
    rd(ACC, v); check("R10 write-back wins on acc", v, 16'h001E);
    @(negedge clk);
    op_valid_i = 1'b1; opcode_i = 8'h35; x_idx_i = 3'd2;
    ld_en_i = 1'b1; ld_idx_i = 4'd3; ld_data_i = 16'h0BEE;
    @(posedge clk); #1;
    op_valid_i = 1'b0; ld_en_i = 1'b0;
    rd(ACC, v);  check("R10 both writes acc", v, 16'h0010);
    rd(4'd3, v); check("R10 both writes r3", v, 16'h0BEE);
  endtask

  task automatic t_readport();
    load(4'd4, 16'h1357);
    @(negedge clk);
    rd_idx_i = 4'd4;
    ld_en_i = 1'b1; ld_idx_i = 4'd4; ld_data_i = 16'h2468;
    @(posedge clk); #1;
    ld_en_i = 1'b0;
    check("R11 read shows pre-edge value", rd_data_o, 16'h1357);
    @(posedge clk); #1;
    check("R11 read shows new value", rd_data_o, 16'h2468);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_add();
    t_sub();
    t_mul();
    t_decinc();
    t_logic();
    t_shift();
    t_illegal();
    t_latency();
    t_collide();
    t_readport();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule